// File: doc/BRIEF.md
# Marker-Bit Asynchronous Serial Transmitter

This block turns a byte written by a host into one asynchronous serial frame on a single output line. A frame is a low start bit, then the eight data bits with the least significant bit first, then a high stop bit. The stop bit is simply the line going back to its idle level. The bit rate comes from a 16x oversampling tick supplied from outside. Internally the ticks drive a divide-by-16 counter that runs all the time, and every bit boundary falls on a rollover of that counter. A write therefore never starts the line at once. The frame begins at the next rollover after the write.

The transmitter keeps no bit counter. A write loads the byte into a 9-bit shift register with a single 1 placed above the most significant data bit. Each shift fills a zero in at the top. When only the marker 1 is left above the last data bit, the controller performs one final shift, ends the frame and raises a done flag. The flag stays set until the host clears it. A write that arrives while a frame is pending or being sent is dropped.

Top module: `marker_uart_tx`

## Requirements
- R1: After reset `tx_line` is 1 and `tx_done` is 0.
- R2: On the line a frame is one 0 bit, then `host_byte[0]` through `host_byte[7]` in that order, then the line held at 1. Each bit lasts 16 ticks of `os_tick`.
- R3: A rollover is the clock edge at which `os_tick` is 1 while the internal tick count holds 15. The count is zeroed by reset, advances only on `os_tick`, and runs whatever the transmitter is doing. A frame's start bit begins at the first rollover after the write, and `tx_line` stays 1 until that edge.
- R4: `tx_done` rises on the edge of the tenth rollover counted from the write. That same edge ends the last data bit, and `tx_line` is 1 from then on.
- R5: Once set, `tx_done` stays 1 until `done_clr` is sampled high, and it is 0 after that edge. If a frame ends on the same edge as a clear, the flag is set.
- R6: A write accepted while a frame is waiting for its first rollover or is on the line is ignored. The bits sent and the completion timing do not change, and no second frame follows.
- R7: With no write pending, `tx_line` stays 1 and `tx_done` stays 0 however many ticks arrive.
- R8: A write on the same edge as a rollover does not use that rollover. The start bit begins at the following rollover, 16 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| host_wr | input | 1 | Write strobe for a new byte |
| host_byte | input | 8 | Byte to send, taken when `host_wr` is accepted |
| done_clr | input | 1 | Clears the done flag |
| tx_line | output | 1 | Serial output, idles high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
Most faults in the marker register show up on the line within one bit time. A misplaced or lost marker moves the end of the frame, so `tx_done` rises a whole bit time or more away from the tenth rollover, or it never rises. A wrong fill value puts wrong data bits on `tx_line`, and the bench samples each of those bits in mid-bit. If the divider were restarted by a write instead of running freely, the start bit would begin off the 16-tick grid that the bench counts from reset, and the bench would see it at the first rollover. A controller that accepts a write while busy changes later data bits or sends a second frame, which the bench sees within one frame.

// File: rtl/mtx_pkg.sv
// Shared types for the marker-bit serial transmitter.
// Assumes: a 2-bit encoding is enough for the controller phases.
package mtx_pkg;

    // Transmit phases: idle, waiting for first rollover, start bit, data bits.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_WAIT  = 2'd1,
        TX_START = 2'd2,
        TX_DATA  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/mtx_baud_div.sv
// Free-running divide-by-OVERSAMPLE counter clocked by the oversampling tick.
// roll_o pulses for one clock on the tick that wraps the counter; that pulse
// marks every bit boundary of the transmitter.
// Assumes: tick_i is a single-cycle pulse; OVERSAMPLE >= 2.
module mtx_baud_div #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic roll_o
);
    localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance the tick count, wrapping after the last state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Rollover pulse: the tick that wraps the counter.
    always_comb begin
        roll_o = tick_i && (cnt_q == CNT_LAST);
    end

endmodule

// File: rtl/mtx_shift_reg.sv
// Marker-bit transmit shift register. A load places the data byte in the low
// bits and a single 1 just above them. A shift moves right and fills 0 at the
// top. last_o flags the state where the marker sits one place above the output
// bit and everything above it is 0.
// Assumes: load_i and shift_i are never high together (load wins if they are).
module mtx_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    output logic              out_bit_o,
    output logic              last_o,
    output logic [DATA_W:0]   sr_o
);
    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0] sr_q;

    // Load byte plus marker, or shift toward the output with zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= {1'b1, data_i};
        end else if (shift_i) begin
            sr_q <= {1'b0, sr_q[SR_W-1:1]};
        end
    end

    // End-of-frame pattern: marker directly above the output bit, zeros above.
    always_comb begin
        last_o = (sr_q[SR_W-1:2] == '0) && sr_q[1];
    end

    assign out_bit_o = sr_q[0];
    assign sr_o      = sr_q;

endmodule

// File: rtl/mtx_ctrl.sv
// Transmit controller. It accepts a write only when idle, then steps through
// wait, start bit and data bits on each rollover. The data phase ends on the
// rollover where the shift register reports the end pattern. It also owns
// the sticky done flag and drives the serial line.
// Assumes: roll_i is a one-cycle pulse; a set of the done flag has priority
// over a clear arriving on the same edge.
module mtx_ctrl
    import mtx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      roll_i,
    input  logic      wr_i,
    input  logic      done_clr_i,
    input  logic      last_i,
    input  logic      out_bit_i,
    output logic      load_o,
    output logic      shift_o,
    output logic      frame_end_o,
    output logic      line_o,
    output logic      done_o,
    output tx_state_e state_o
);
    tx_state_e state_q;
    tx_state_e state_d;
    logic      done_q;

    // Next-phase decode and the load/shift/end strobes.
    always_comb begin
        state_d     = state_q;
        load_o      = 1'b0;
        shift_o     = 1'b0;
        frame_end_o = 1'b0;
        case (state_q)
            TX_IDLE: begin
                if (wr_i) begin
                    load_o  = 1'b1;
                    state_d = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (roll_i) begin
                    state_d = TX_START;
                end
            end
            TX_START: begin
                if (roll_i) begin
                    state_d = TX_DATA;
                end
            end
            TX_DATA: begin
                if (roll_i) begin
                    shift_o = 1'b1;
                    if (last_i) begin
                        frame_end_o = 1'b1;
                        state_d     = TX_IDLE;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky done flag: set at frame end, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (frame_end_o) begin
            done_q <= 1'b1;
        end else if (done_clr_i) begin
            done_q <= 1'b0;
        end
    end

    // Line level: low for the start bit, register output for data, else high.
    always_comb begin
        case (state_q)
            TX_START: line_o = 1'b0;
            TX_DATA:  line_o = out_bit_i;
            default:  line_o = 1'b1;
        endcase
    end

    assign done_o  = done_q;
    assign state_o = state_q;

endmodule

// File: rtl/marker_uart_tx.sv
// Top of the marker-bit serial transmitter: divider, shift register and
// controller. Sends start, DATA_W data bits LSB first, and returns the line
// high; the done flag is set at the end of the last data bit.
// Assumes: os_tick is a one-cycle pulse at OVERSAMPLE times the bit rate.
module marker_uart_tx #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_byte,
    input  logic              done_clr,
    output logic              tx_line,
    output logic              tx_done
);
    import mtx_pkg::*;

    logic            roll_w;
    logic            load_w;
    logic            shift_w;
    logic            last_w;
    logic            out_bit_w;
    logic            frame_end_w;
    logic [DATA_W:0] sr_w;
    tx_state_e       state_w;

    mtx_baud_div #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (os_tick),
        .roll_o (roll_w)
    );

    mtx_shift_reg #(
        .DATA_W (DATA_W)
    ) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .data_i    (host_byte),
        .shift_i   (shift_w),
        .out_bit_o (out_bit_w),
        .last_o    (last_w),
        .sr_o      (sr_w)
    );

    mtx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .roll_i      (roll_w),
        .wr_i        (host_wr),
        .done_clr_i  (done_clr),
        .last_i      (last_w),
        .out_bit_i   (out_bit_w),
        .load_o      (load_w),
        .shift_o     (shift_w),
        .frame_end_o (frame_end_w),
        .line_o      (tx_line),
        .done_o      (tx_done),
        .state_o     (state_w)
    );

endmodule

// File: rtl/mtx_checker.sv
// Assertion checker for marker_uart_tx, attached with the bind below.
// Assumes: the internal nets named in the bind exist in the top module.
module mtx_checker #(
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               done_clr,
    input logic               tx_line,
    input logic               tx_done,
    input logic               roll,
    input logic               frame_end,
    input mtx_pkg::tx_state_e state,
    input logic [DATA_W:0]    sr
);
    import mtx_pkg::*;

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !done_clr) |=> tx_done);

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !frame_end) |=> !tx_done);

    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> tx_done);

    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_done && !frame_end) |=> !tx_done);

    // R3
    end_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> roll);

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE || state == TX_WAIT) |-> tx_line);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START) |-> !tx_line);

    // R6
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != TX_IDLE) && host_wr && !roll) |=> $stable(sr));

    // R8
    no_skip_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |=> (state != TX_START));

endmodule

bind marker_uart_tx mtx_checker #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .done_clr  (done_clr),
    .tx_line   (tx_line),
    .tx_done   (tx_done),
    .roll      (roll_w),
    .frame_end (frame_end_w),
    .state     (state_w),
    .sr        (sr_w)
);

// File: tb/marker_uart_tx_test.sv
// Bench for marker_uart_tx: a vector table of bytes and expected frames,
// walked by one loop, then directed checks for reset and corner cases.
module marker_uart_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       done_clr = 1'b0;
    logic       tx_line;
    logic       tx_done;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_count = 0;

    // Each entry: {byte, expected frame}; frame bit 0 is sent first.
    localparam int NV = 6;
    localparam logic [17:0] VEC [NV] = '{
        {8'h00, 1'b1, 8'h00, 1'b0},
        {8'hFF, 1'b1, 8'hFF, 1'b0},
        {8'hA5, 1'b1, 8'hA5, 1'b0},
        {8'h5A, 1'b1, 8'h5A, 1'b0},
        {8'h01, 1'b1, 8'h01, 1'b0},
        {8'h80, 1'b1, 8'h80, 1'b0}
    };

    marker_uart_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .host_wr   (host_wr),
        .host_byte (host_byte),
        .done_clr  (done_clr),
        .tx_line   (tx_line),
        .tx_done   (tx_done)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One oversampling tick, then a gap cycle; returns at a falling edge.
    task automatic do_tick();
        @(negedge clk) os_tick = 1'b1;
        @(negedge clk) os_tick = 1'b0;
        tick_count++;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        host_wr   = 1'b1;
        host_byte = d;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic clear_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    // mode: 0 plain, 1 extra write mid-frame, 2 extra write while waiting,
    // 3 byte already written by the caller.
    task automatic run_frame(input logic [7:0] d, input logic [9:0] frame,
                             input int mode, input string align_tag);
        if (mode != 3) write_byte(d);
        if (mode == 2) write_byte(~d);
        while (((tick_count + 1) % 16) != 0) do_tick();
        check({align_tag, " line idle before rollover"}, tx_line, 1'b1);
        do_tick();
        check({align_tag, " start at rollover"}, tx_line, 1'b0);
        for (int b = 0; b < 9; b++) begin
            repeat (8) do_tick();
            check(mode == 0 ? "R2 bit" : "R6 bit", tx_line, frame[b]);
            if (mode == 1 && b == 4) write_byte(~d);
            repeat (7) do_tick();
            if (b == 8) check("R4 done low before tenth rollover", tx_done, 1'b0);
            do_tick();
        end
        check("R4 done at tenth rollover", tx_done, 1'b1);
        check("R4 line high for stop", tx_line, frame[9]);
    endtask

    initial begin
        logic saw_bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line after reset", tx_line, 1'b1);
        check("R1 done after reset", tx_done, 1'b0);

        // R7: ticks with no write leave the line idle.
        saw_bad = 1'b0;
        repeat (37) begin
            do_tick();
            if (tx_line !== 1'b1 || tx_done !== 1'b0) saw_bad = 1'b1;
        end
        check("R7 idle under ticks", saw_bad, 1'b0);

        // Vector table, each frame from an off-grid write point.
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][17:10], VEC[i][9:0],
                      (i == 2) ? 1 : ((i == 4) ? 2 : 0), "R3");
            repeat (3) do_tick();
            check("R5 done sticky", tx_done, 1'b1);
            clear_done();
            check("R5 done cleared", tx_done, 1'b0);
            if (i == 2 || i == 4) begin
                saw_bad = 1'b0;
                repeat (40) begin
                    do_tick();
                    if (tx_line !== 1'b1 || tx_done !== 1'b0) saw_bad = 1'b1;
                end
                check("R6 no second frame", saw_bad, 1'b0);
            end
            repeat (i + 1) do_tick();
        end

        // R8: write on the same edge as a rollover.
        while (((tick_count + 1) % 16) != 0) do_tick();
        @(negedge clk);
        os_tick   = 1'b1;
        host_wr   = 1'b1;
        host_byte = 8'h3C;
        @(negedge clk);
        os_tick   = 1'b0;
        host_wr   = 1'b0;
        tick_count++;
        check("R8 line idle on coinciding rollover", tx_line, 1'b1);
        run_frame(8'h3C, {1'b1, 8'h3C, 1'b0}, 3, "R8");

        // R5: clear coinciding with frame end loses to the set.
        write_byte(8'h96);
        while (((tick_count + 1) % 16) != 0) do_tick();
        do_tick();
        repeat (9 * 16 - 1) do_tick();
        @(negedge clk);
        os_tick  = 1'b1;
        done_clr = 1'b1;
        @(negedge clk);
        os_tick  = 1'b0;
        done_clr = 1'b0;
        tick_count++;
        check("R5 set wins over clear", tx_done, 1'b1);

        // R1: reset mid-frame returns to idle.
        write_byte(8'h00);
        while (((tick_count + 1) % 16) != 0) do_tick();
        repeat (20) do_tick();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 line after mid-frame reset", tx_line, 1'b1);
        check("R1 done after mid-frame reset", tx_done, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule